// File: doc/BRIEF.md
# Half-Bridge Oscillator and Operating-Mode Sequencer

This block controls a half-bridge gate driver. It decides which of four operating modes the driver is in: supply lockout, run, dim or latched fault. In run mode it produces a low-side gate and a high-side gate that switch in turn. Each gate is on for half of the period, minus a fixed dead time. The dead time is counted in clock cycles and comes before every turn-on. The length of one half period is set by an input word, and this is how an outer loop sets the switching frequency. With the default parameters and a 100 MHz clock, a word of 1124 gives about 44.5 kHz. The dead time is 160 cycles, which is 1.6 µs.

The inputs are flags from comparators outside the block: a supply-good flag, a flag that says the high-side bootstrap supply is good, an enable comparator output that already has hysteresis (high means stop the load), and a fault request from the current-sense event counter. The block drives the following outputs:
- the two gate signals;
- the bootstrap-charging switch enable, which is on during the low-side on-time;
- an enable for the power-factor stage;
- a request to clear the stored on-time of the power-factor stage;
- the mode code.

Dim mode keeps the on-time of the power-factor stage so that it can restart quickly. Fault mode clears that on-time and stays latched until the supply drops away.

Top module: `hb_mode_ctrl`

## Requirements
- R1: During reset, and in lockout mode (code 0), both gates, the bootstrap switch and the power-factor enable are low, and the power-factor clear request is high.
- R2: Lockout moves to run (code 1) at the first clock edge that sees the supply flag high and the enable input low. While the enable input is high, the block stays in lockout.
- R3: Count the run cycles from k = 0, the first cycle in run mode. Let H be the half-period word, or DEAD_CYC+1 if the word is not larger than DEAD_CYC. The switching period is 2H cycles. The low-side gate is high for k in [DEAD_CYC, H-1] of each period, and the high-side slot is [H+DEAD_CYC, 2H-1]. The two gates are never high together, so each turn-on follows DEAD_CYC cycles with both gates low.
- R4: The high-side gate switches in a half only if the bootstrap flag was high at the clock edge that started that half. Otherwise it stays low, and the low-side gate keeps switching.
- R5: The bootstrap switch enable is high exactly when the low-side gate is high.
- R6: In run mode, a high enable input moves the block to dim (code 2) at the next edge. In dim, both gates and the power-factor enable are low and the clear request is low. A low enable input returns the block to run, and the oscillator restarts at k = 0.
- R7: A fault request seen in run or dim moves the block to fault (code 3). This takes priority over the enable input. In fault, the gates and the power-factor enable are low and the clear request is high.
- R8: Fault mode is latched. Enable changes and further fault requests do not take the block out of it; only a low supply flag moves it to lockout. A fault request seen in lockout is ignored.
- R9: A low supply flag moves the block from any mode to lockout at the next edge. In every mode other than run, both gates are low from the first cycle of that mode.
- R10: The half-period word is sampled at the edge that starts each half. A change in the middle of a half takes effect from the next half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| supply_ok_i | input | 1 | Supply above its start threshold |
| boot_ok_i | input | 1 | High-side bootstrap supply valid |
| enable_hi_i | input | 1 | Enable comparator output; high stops the load |
| fault_req_i | input | 1 | Fault request from the current-sense counter |
| half_period_i | input | CNT_W | Half-period length in clock cycles |
| hs_gate_o | output | 1 | High-side gate command |
| ls_gate_o | output | 1 | Low-side gate command |
| boot_sw_o | output | 1 | Bootstrap charging switch enable |
| pfc_en_o | output | 1 | Power-factor stage enable |
| pfc_clear_o | output | 1 | Clear the stored power-factor on-time |
| mode_o | output | 2 | Mode code: 0 lockout, 1 run, 2 dim, 3 fault |

## Verification
The bench builds the block with CNT_W = 5 and DEAD_CYC = 3. At these values a full switching period is only a few cycles long. This lets the bench sweep every half-period word from 0 to 12, including the words that are clamped up to DEAD_CYC+1, and count the on-cycles of each gate over a whole period for each word. The same short periods also put every mode transition within a few cycles of a gate edge. This includes a supply loss while a gate is on, a mid-half change of the period word, and bootstrap-flag changes around the edge that starts a half.

// File: rtl/hbmc_pkg.sv
package hbmc_pkg;

    typedef enum logic [1:0] {
        MODE_LOCKOUT = 2'd0,
        MODE_RUN     = 2'd1,
        MODE_DIM     = 2'd2,
        MODE_FAULT   = 2'd3
    } hb_mode_e;

    typedef struct packed {
        hb_mode_e mode;
    } seq_state_t;

endpackage

// File: rtl/hbmc_mode_seq.sv
module hbmc_mode_seq
    import hbmc_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     supply_ok_i,
    input  logic     enable_hi_i,
    input  logic     fault_req_i,
    output hb_mode_e mode_o
);

    seq_state_t st_d, st_q;

    // Next-mode selection; supply loss overrides every other condition.
    always_comb begin
        st_d = st_q;
        if (!supply_ok_i) begin
            st_d.mode = MODE_LOCKOUT;
        end else begin
            unique case (st_q.mode)
                MODE_LOCKOUT: if (!enable_hi_i) st_d.mode = MODE_RUN;
                MODE_RUN, MODE_DIM: begin
                    if (fault_req_i)      st_d.mode = MODE_FAULT;
                    else if (enable_hi_i) st_d.mode = MODE_DIM;
                    else                  st_d.mode = MODE_RUN;
                end
                MODE_FAULT:   st_d.mode = MODE_FAULT;
                default:      st_d.mode = MODE_LOCKOUT;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{mode: MODE_LOCKOUT};
        else         st_q <= st_d;
    end

    assign mode_o = st_q.mode;

    // R8: a latched fault survives while the supply stays good
    assert_fault_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode == MODE_FAULT && supply_ok_i) |=> (st_q.mode == MODE_FAULT));

    // R9: supply loss always lands in lockout
    assert_lockout_on_loss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !supply_ok_i |=> (st_q.mode == MODE_LOCKOUT));

    // R7: fault request wins over the enable input
    assert_fault_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.mode == MODE_RUN || st_q.mode == MODE_DIM) && supply_ok_i && fault_req_i)
        |=> (st_q.mode == MODE_FAULT));

endmodule

// File: rtl/hbmc_osc.sv
module hbmc_osc #(
    parameter int CNT_W    = 12,
    parameter int DEAD_CYC = 160
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             boot_ok_i,
    input  logic [CNT_W-1:0] half_period_i,
    output logic             lo_on_o,
    output logic             ho_on_o
);

    localparam logic [CNT_W-1:0] DEAD_W   = CNT_W'(DEAD_CYC);
    localparam logic [CNT_W-1:0] MIN_HALF = CNT_W'(DEAD_CYC + 1);
    localparam logic [CNT_W-1:0] ONE_W    = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hp;
        logic             ho_half;
        logic             hs_allow;
    } osc_state_t;

    osc_state_t st_d, st_q;
    logic [CNT_W-1:0] hp_eff;
    logic             half_end;
    logic             past_dead;

    // A half shorter than the dead time plus one cycle is stretched.
    assign hp_eff    = (half_period_i <= DEAD_W) ? MIN_HALF : half_period_i;
    assign half_end  = (st_q.cnt == (st_q.hp - ONE_W));
    assign past_dead = (st_q.cnt >= DEAD_W);

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.cnt      = '0;
            st_d.ho_half  = 1'b0;
            st_d.hp       = hp_eff;
            st_d.hs_allow = 1'b0;
        end else if (half_end) begin
            st_d.cnt      = '0;
            st_d.ho_half  = !st_q.ho_half;
            st_d.hp       = hp_eff;
            st_d.hs_allow = !st_q.ho_half && boot_ok_i;
        end else begin
            st_d.cnt      = st_q.cnt + ONE_W;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{cnt: '0, hp: MIN_HALF, ho_half: 1'b0, hs_allow: 1'b0};
        else         st_q <= st_d;
    end

    assign lo_on_o = run_i && !st_q.ho_half && past_dead;
    assign ho_on_o = run_i &&  st_q.ho_half && past_dead && st_q.hs_allow;

    // R3: the gates never overlap
    assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(lo_on_o && ho_on_o));

    // R3: a low-side turn-on never follows the high side directly
    assert_lo_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lo_on_o) |-> !$past(ho_on_o));

    // R3: a high-side turn-on never follows the low side directly
    assert_ho_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ho_on_o) |-> !$past(lo_on_o));

    // R9: switching stops in the cycle run ends
    assert_stop_on_leave_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> (!lo_on_o && !ho_on_o));

endmodule

// File: rtl/hb_mode_ctrl.sv
module hb_mode_ctrl
    import hbmc_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int DEAD_CYC = 160
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             supply_ok_i,
    input  logic             boot_ok_i,
    input  logic             enable_hi_i,
    input  logic             fault_req_i,
    input  logic [CNT_W-1:0] half_period_i,
    output logic             hs_gate_o,
    output logic             ls_gate_o,
    output logic             boot_sw_o,
    output logic             pfc_en_o,
    output logic             pfc_clear_o,
    output logic [1:0]       mode_o
);

    hb_mode_e mode_q;
    logic     run;
    logic     lo_on;
    logic     ho_on;

    hbmc_mode_seq seq_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .supply_ok_i (supply_ok_i),
        .enable_hi_i (enable_hi_i),
        .fault_req_i (fault_req_i),
        .mode_o      (mode_q)
    );

    assign run = (mode_q == MODE_RUN);

    hbmc_osc #(
        .CNT_W    (CNT_W),
        .DEAD_CYC (DEAD_CYC)
    ) osc_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .run_i         (run),
        .boot_ok_i     (boot_ok_i),
        .half_period_i (half_period_i),
        .lo_on_o       (lo_on),
        .ho_on_o       (ho_on)
    );

    assign ls_gate_o   = lo_on;
    assign hs_gate_o   = ho_on;
    assign boot_sw_o   = lo_on;
    assign pfc_en_o    = run;
    assign pfc_clear_o = (mode_q == MODE_LOCKOUT) || (mode_q == MODE_FAULT);
    assign mode_o      = mode_q;

    // R1: lockout keeps every drive output quiet
    assert_lockout_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'd0) |-> (!hs_gate_o && !ls_gate_o && !pfc_en_o && pfc_clear_o));

    // R6: dim mode holds the gates low but keeps the on-time state
    assert_dim_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'd2) |-> (!hs_gate_o && !ls_gate_o && !pfc_en_o && !pfc_clear_o));

    // R7: fault mode holds all drives low and clears the on-time state
    assert_fault_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'd3) |-> (!hs_gate_o && !ls_gate_o && !pfc_en_o && pfc_clear_o));

endmodule

// File: tb/hb_mode_ctrl_tb_top.sv
module hb_mode_ctrl_tb_top;

    localparam int CW = 5;
    localparam int DC = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          sup = 1'b0, boot = 1'b0, en = 1'b0, flt = 1'b0;
    logic [CW-1:0] hp = '0;
    logic          hs, ls, bsw, pen, pclr;
    logic [1:0]    mode;

    hb_mode_ctrl #(.CNT_W(CW), .DEAD_CYC(DC)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(sup), .boot_ok_i(boot),
        .enable_hi_i(en), .fault_req_i(flt), .half_period_i(hp),
        .hs_gate_o(hs), .ls_gate_o(ls), .boot_sw_o(bsw), .pfc_en_o(pen),
        .pfc_clear_o(pclr), .mode_o(mode)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    done = 0;
    string tag = "R1";

    // expected state derived from the requirements
    int e_mode = 0, e_k = 0, e_ph = 0, e_H = DC + 1, e_allow = 0;

    function automatic int eff(int h);
        return (h <= DC) ? DC + 1 : h;
    endfunction

    task automatic chk(string rq, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic compare();
        int run, x_ls, x_hs;
        run  = (e_mode == 1);
        x_ls = (run && e_ph == 0 && e_k >= DC) ? 1 : 0;
        x_hs = (run && e_ph == 1 && e_k >= DC && e_allow == 1) ? 1 : 0;
        chk(tag, "mode", int'(mode), e_mode);
        chk(tag, "ls_gate", int'(ls), x_ls);
        chk(tag, "hs_gate", int'(hs), x_hs);
        chk("R5", "boot_sw", int'(bsw), x_ls);
        chk(tag, "pfc_en", int'(pen), run);
        chk(tag, "pfc_clear", int'(pclr), (e_mode == 0 || e_mode == 3) ? 1 : 0);
    endtask

    // drive one cycle at the falling edge, advance the expectation, sample next falling edge
    task automatic step(logic s, logic b, logic e, logic f, int h);
        int nm;
        sup = s; boot = b; en = e; flt = f; hp = CW'(h);
        if (!s) nm = 0;
        else case (e_mode)
            0:       nm = e ? 0 : 1;
            1, 2:    nm = f ? 3 : (e ? 2 : 1);
            default: nm = 3;
        endcase
        @(posedge clk);
        if (e_mode != 1) begin
            e_k = 0; e_ph = 0; e_H = eff(h); e_allow = 0;
        end else if (e_k == e_H - 1) begin
            e_allow = (e_ph == 0 && b) ? 1 : 0;
            e_ph = 1 - e_ph; e_k = 0; e_H = eff(h);
        end else begin
            e_k++;
        end
        e_mode = nm;
        @(negedge clk);
        compare();
    endtask

    task automatic restart_measure(int h);
        int lo_n, hi_n, first_lo, H;
        H = eff(h);
        tag = "R6";
        step(1, 1, 1, 0, h);
        chk("R6", "dim entry", int'(mode), 2);
        tag = "R3";
        step(1, 1, 0, 0, h);
        lo_n = int'(ls); hi_n = int'(hs);
        first_lo = ls ? 0 : -1;
        for (int i = 1; i < 2 * H; i++) begin
            step(1, 1, 0, 0, h);
            lo_n += int'(ls); hi_n += int'(hs);
            if (ls && first_lo < 0) first_lo = i;
        end
        chk("R3", "lo on-cycles", lo_n, H - DC);
        chk("R3", "ho on-cycles", hi_n, H - DC);
        chk("R3", "first lo cycle", first_lo, DC);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int hcnt;
        repeat (3) @(negedge clk);
        tag = "R1";
        compare();
        rst_n = 1'b1;
        step(0, 0, 0, 0, 6);
        step(0, 1, 0, 1, 6);
        step(0, 0, 1, 0, 6);

        tag = "R2";
        repeat (4) step(1, 0, 1, 0, 6);
        tag = "R8";
        step(1, 0, 1, 1, 6);
        chk("R8", "fault in lockout ignored", int'(mode), 0);
        tag = "R2";
        step(1, 0, 0, 0, 6);
        chk("R2", "run entry", int'(mode), 1);

        tag = "R4";
        hcnt = 0;
        repeat (30) begin step(1, 0, 0, 0, 6); hcnt += int'(hs); end
        chk("R4", "ho without bootstrap", hcnt, 0);
        repeat (30) step(1, 1, 0, 0, 6);
        // bootstrap flag pulses only around some half starts
        for (int i = 0; i < 40; i++) step(1, (i % 5) == 2, 0, 0, 5);

        for (int h = 0; h <= 12; h++) restart_measure(h);

        tag = "R10";
        for (int i = 0; i < 50; i++) step(1, 1, 0, 0, (i % 7 == 3) ? 5 : ((i % 11 == 4) ? 9 : 7));

        tag = "R6";
        repeat (5) step(1, 1, 1, 0, 6);
        repeat (12) step(1, 1, 0, 0, 6);

        tag = "R7";
        step(1, 1, 1, 0, 6);
        step(1, 1, 1, 1, 6);
        chk("R7", "fault from dim", int'(mode), 3);
        tag = "R8";
        for (int i = 0; i < 12; i++) step(1, i[0], i[1], i[2], 6);
        chk("R8", "fault latched", int'(mode), 3);
        tag = "R9";
        step(0, 1, 0, 0, 6);
        chk("R9", "fault exit via lockout", int'(mode), 0);
        tag = "R2";
        step(1, 1, 0, 0, 6);
        repeat (8) step(1, 1, 0, 0, 6);
        tag = "R7";
        step(1, 1, 1, 1, 6);
        chk("R7", "fault beats enable", int'(mode), 3);
        step(0, 1, 0, 0, 6);
        step(1, 1, 0, 0, 6);

        tag = "R9";
        for (int d = 0; d < 14; d++) begin
            repeat (d) step(1, 1, 0, 0, 6);
            step(0, 1, 0, 0, 6);
            chk("R9", "gates low on supply loss", int'(hs) + int'(ls), 0);
            step(1, 1, 0, 0, 6);
        end
        step(1, 1, 1, 0, 6);
        step(0, 1, 1, 0, 6);
        chk("R9", "dim to lockout", int'(mode), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule